// File: doc/BRIEF.md
# Circular Scratch Burst Address Generator

This block sits between a transfer sequencer and a byte-addressed scratch memory port. It accepts one transfer request at a time and turns it into a series of burst requests, each with an address and a byte length. The request carries a base address, a starting offset, a stored size field, a total byte length and a 4-bit buffer selector. The stored size field holds the buffer size minus one.

With the circular selector, the transfer is cut at every point where the buffer wraps. Each burst starts at base plus the running offset, and the offset returns to zero whenever it reaches the buffer size. With the linear selector, the whole transfer goes out as one burst at base plus offset. The four FIFO selectors send one burst flagged for a FIFO target and do not use scratch addressing. When the transfer ends, a one-cycle done pulse reports the final offset so the sequencer can write it back.

The state machine has three states. IDLE accepts a request (transition ACCEPT). BURST presents the current burst and stays there until the burst is taken (transition ISSUE). It moves on after the last burst (transition LAST), or after a zero-length or unsupported request (transition SKIP, taken directly from IDLE). DONE lasts one cycle and always returns to IDLE (transition RETIRE).

Top module: `sbag_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `bst_valid` and `done` are 0.
- R2: The effective buffer size is `req_size_m1` + 1. With `req_size_m1` at its maximum (all ones), the size is 2^LEN_W.
- R3: In circular mode (`req_buf` = 14), a nonzero-length transfer whose starting offset is at or beyond the effective size starts from offset 0.
- R4: In circular mode, each burst has address `req_base` + current offset and length min(remaining bytes, size − offset), with `bst_to_fifo` = 0.
- R5: After each circular burst, the offset advances by the burst length and becomes 0 when it reaches the size. The final value is reported on `done_offset`.
- R6: In linear mode (`req_buf` = 15), exactly one burst of the full length goes out at `req_base` + `req_offset`. No range correction is applied, and `done_offset` equals `req_offset`.
- R7: For `req_buf` 0 to 3, exactly one burst goes out with `bst_to_fifo` = 1, `bst_fifo_idx` = `req_buf`[1:0], address 0 and the full length. `done_offset` equals `req_offset`.
- R8: While `bst_valid` is 1 and `bst_ready` is 0, `bst_valid`, `bst_addr`, `bst_len`, `bst_to_fifo` and `bst_fifo_idx` hold their values into the next cycle.
- R9: `done` is 1 for exactly one cycle. That cycle immediately follows acceptance of the last burst, and `done` is never 1 together with `bst_valid`.
- R10: A request with `req_len` = 0 issues no burst. `done` rises in the cycle after acceptance, and `done_offset` equals `req_offset` even when that offset is out of range.
- R11: Selectors 4 to 13 issue no burst. `done` follows acceptance, and `done_offset` equals `req_offset`.
- R12: `req_ready` is 0 from acceptance until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_base | input | ADDR_W | Scratch base address |
| req_offset | input | LEN_W | Starting offset within buffer |
| req_size_m1 | input | LEN_W | Buffer size minus one |
| req_len | input | LEN_W | Total transfer length in bytes |
| req_buf | input | 4 | Buffer selector (0-3 FIFO, 14 circular, 15 linear) |
| bst_valid | output | 1 | Burst request present |
| bst_ready | input | 1 | Burst request taken when valid |
| bst_addr | output | ADDR_W | Burst byte address |
| bst_len | output | LEN_W | Burst length in bytes |
| bst_to_fifo | output | 1 | Burst targets a FIFO rather than scratch |
| bst_fifo_idx | output | 2 | FIFO target index |
| done | output | 1 | One-cycle completion pulse |
| done_offset | output | LEN_W | Final offset for writeback, valid with done |

## Verification
The bench builds the block with LEN_W = 8 and ADDR_W = 16. This makes the largest buffer only 256 bytes, so the wrap at the very top of the size range, the all-ones size field and a request that wraps several times all fit in a few dozen cycles. Offsets beyond the size (16 against a 16-byte buffer, 200 against 16) are easy to reach with these widths. So are transfers that end exactly on the wrap point. Stalling the burst handshake on the first cycle of every burst exposes the hold behaviour on every split.

// File: rtl/sbag_pkg.sv
package sbag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } sbag_state_e;

    typedef enum logic [1:0] {
        MODE_FIFO = 2'd0,
        MODE_CIRC = 2'd1,
        MODE_LIN  = 2'd2,
        MODE_NONE = 2'd3
    } sbag_mode_e;

    localparam logic [3:0] SEL_CIRC = 4'hE;
    localparam logic [3:0] SEL_LIN  = 4'hF;

endpackage

// File: rtl/sbag_classify.sv
module sbag_classify
    import sbag_pkg::*;
(
    input  logic [3:0]  sel,
    output sbag_mode_e  mode,
    output logic [1:0]  fifo_idx
);
    always_comb begin
        fifo_idx = sel[1:0];
        if (sel == SEL_CIRC)
            mode = MODE_CIRC;
        else if (sel == SEL_LIN)
            mode = MODE_LIN;
        else if (sel[3:2] == 2'b00)
            mode = MODE_FIFO;
        else
            mode = MODE_NONE;
    end
endmodule

// File: rtl/sbag_step.sv
module sbag_step
    import sbag_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int SZ_W = LEN_W + 1
) (
    input  sbag_mode_e        mode,
    input  logic [LEN_W-1:0]  offset,
    input  logic [SZ_W-1:0]   size_eff,
    input  logic [LEN_W-1:0]  remaining,
    output logic [LEN_W-1:0]  chunk,
    output logic [LEN_W-1:0]  next_offset
);
    logic [SZ_W-1:0] room;
    logic [SZ_W-1:0] reach;

    always_comb begin
        room  = size_eff - {1'b0, offset};
        chunk = remaining;
        if (mode == MODE_CIRC && room < {1'b0, remaining})
            chunk = room[LEN_W-1:0];
        reach = {1'b0, offset} + {1'b0, chunk};
        if (mode != MODE_CIRC)
            next_offset = offset;
        else if (reach >= size_eff)
            next_offset = '0;
        else
            next_offset = reach[LEN_W-1:0];
    end
endmodule

// File: rtl/sbag_top.sv
module sbag_top
    import sbag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [LEN_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]  req_size_m1,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [3:0]        req_buf,
    output logic              bst_valid,
    input  logic              bst_ready,
    output logic [ADDR_W-1:0] bst_addr,
    output logic [LEN_W-1:0]  bst_len,
    output logic              bst_to_fifo,
    output logic [1:0]        bst_fifo_idx,
    output logic              done,
    output logic [LEN_W-1:0]  done_offset
);
    localparam int SZ_W = LEN_W + 1;

    sbag_state_e      state, state_nx;
    sbag_mode_e       in_mode, r_mode;
    logic [1:0]       in_fidx, r_fidx;
    logic [ADDR_W-1:0] r_base;
    logic [LEN_W-1:0] r_off, r_rem;
    logic [SZ_W-1:0]  r_size, in_size;
    logic [LEN_W-1:0] chunk, next_off;
    logic             accept, take, skip, last;

    sbag_classify u_cls (
        .sel      (req_buf),
        .mode     (in_mode),
        .fifo_idx (in_fidx)
    );

    sbag_step #(.LEN_W(LEN_W)) u_step (
        .mode        (r_mode),
        .offset      (r_off),
        .size_eff    (r_size),
        .remaining   (r_rem),
        .chunk       (chunk),
        .next_offset (next_off)
    );

    assign in_size = {1'b0, req_size_m1} + SZ_W'(1);
    assign accept  = (state == ST_IDLE) && req_valid;
    assign take    = (state == ST_BURST) && bst_ready;
    assign skip    = (req_len == '0) || (in_mode == MODE_NONE);
    assign last    = (r_rem == chunk);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = skip ? ST_DONE : ST_BURST;
            ST_BURST: if (take && last) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_mode <= MODE_NONE;
            r_fidx <= '0;
            r_base <= '0;
            r_off  <= '0;
            r_rem  <= '0;
            r_size <= '0;
        end else if (accept) begin
            r_mode <= in_mode;
            r_fidx <= in_fidx;
            r_base <= req_base;
            r_rem  <= req_len;
            r_size <= in_size;
            if (in_mode == MODE_CIRC && req_len != '0 &&
                {1'b0, req_offset} >= in_size)
                r_off <= '0;
            else
                r_off <= req_offset;
        end else if (take) begin
            r_rem <= r_rem - chunk;
            r_off <= next_off;
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        bst_valid    = (state == ST_BURST);
        done         = (state == ST_DONE);
        done_offset  = r_off;
        bst_len      = chunk;
        bst_to_fifo  = (r_mode == MODE_FIFO);
        bst_fifo_idx = r_fidx;
        if (r_mode == MODE_FIFO)
            bst_addr = '0;
        else
            bst_addr = r_base + ADDR_W'(r_off);
    end
endmodule

// File: rtl/sbag_checker.sv
module sbag_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bst_valid,
    input logic              bst_ready,
    input logic [ADDR_W-1:0] bst_addr,
    input logic [LEN_W-1:0]  bst_len,
    input logic              bst_to_fifo,
    input logic [1:0]        bst_fifo_idx,
    input logic              done
);
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) &&
            $stable(bst_len) && $stable(bst_to_fifo) && $stable(bst_fifo_idx)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready) |=> (bst_valid || done));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && bst_valid));

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid || done) |-> !req_ready);

    p_done_then_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    p_nonzero_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_len != '0));
endmodule

bind sbag_top sbag_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .bst_valid    (bst_valid),
    .bst_ready    (bst_ready),
    .bst_addr     (bst_addr),
    .bst_len      (bst_len),
    .bst_to_fifo  (bst_to_fifo),
    .bst_fifo_idx (bst_fifo_idx),
    .done         (done)
);

// File: tb/sim_sbag_top.sv
module sim_sbag_top;
    localparam int AW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [LW-1:0] req_offset = '0;
    logic [LW-1:0] req_size_m1 = '0;
    logic [LW-1:0] req_len = '0;
    logic [3:0]    req_buf = '0;
    logic          bst_valid;
    logic          bst_ready = 1'b0;
    logic [AW-1:0] bst_addr;
    logic [LW-1:0] bst_len;
    logic          bst_to_fifo;
    logic [1:0]    bst_fifo_idx;
    logic          done;
    logic [LW-1:0] done_offset;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sbag_top #(.ADDR_W(AW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_offset(req_offset), .req_size_m1(req_size_m1),
        .req_len(req_len), .req_buf(req_buf), .bst_valid(bst_valid),
        .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_len(bst_len),
        .bst_to_fifo(bst_to_fifo), .bst_fifo_idx(bst_fifo_idx), .done(done),
        .done_offset(done_offset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected burst list from the requirements
    int e_addr[32];
    int e_len[32];
    int e_fifo[32];
    int e_n;
    int e_final;

    task automatic model(input int sel, input int base, input int off,
                         input int szm1, input int len);
        int size = szm1 + 1;
        int o = off;
        int rem = len;
        e_n = 0;
        e_final = off;
        if (len == 0) return;
        if (sel < 4) begin
            e_addr[0] = 0; e_len[0] = len; e_fifo[0] = 1; e_n = 1;
        end else if (sel == 15) begin
            e_addr[0] = (base + off) % 65536; e_len[0] = len; e_fifo[0] = 0; e_n = 1;
        end else if (sel == 14) begin
            if (o >= size) o = 0;
            while (rem > 0) begin
                int c = (rem < size - o) ? rem : size - o;
                e_addr[e_n] = (base + o) % 65536; e_len[e_n] = c; e_fifo[e_n] = 0;
                e_n++;
                rem -= c;
                o += c;
                if (o >= size) o = 0;
            end
            e_final = o;
        end
    endtask

    task automatic xfer(input string req, input int sel, input int base, input int off,
                        input int szm1, input int len, input bit stall);
        int n = 0;
        int cyc = 0;
        int last_take = -1;
        bit held = 0;
        bit fin = 0;
        logic [AW-1:0] h_addr;
        logic [LW-1:0] h_len;
        model(sel, base, off, szm1, len);
        @(negedge clk);
        chk({req, " R12 idle ready"}, int'(req_ready), 1);
        req_buf = sel[3:0]; req_base = base[AW-1:0]; req_offset = off[LW-1:0];
        req_size_m1 = szm1[LW-1:0]; req_len = len[LW-1:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin && cyc < 400) begin
            if (done) begin
                fin = 1;
                bst_ready = 1'b0;
                chk({req, " R9 done right after last take"}, cyc, last_take + 1);
                chk({req, " R5 done_offset"}, int'(done_offset), e_final);
                chk({req, " burst count"}, n, e_n);
            end else begin
                if (req_ready) chk({req, " R12 ready while busy"}, 1, 0);
                if (bst_valid) begin
                    if (stall && !held) begin
                        bst_ready = 1'b0; held = 1; h_addr = bst_addr; h_len = bst_len;
                    end else begin
                        if (held) begin
                            chk({req, " R8 addr held"}, int'(bst_addr), int'(h_addr));
                            chk({req, " R8 len held"}, int'(bst_len), int'(h_len));
                        end
                        held = 0;
                        bst_ready = 1'b1;
                        if (n < e_n) begin
                            chk({req, " R4 burst addr"}, int'(bst_addr), e_addr[n]);
                            chk({req, " R4 burst len"}, int'(bst_len), e_len[n]);
                            chk({req, " R7 fifo flag"}, int'(bst_to_fifo), e_fifo[n]);
                            if (e_fifo[n] == 1)
                                chk({req, " R7 fifo idx"}, int'(bst_fifo_idx), sel % 4);
                        end
                        n++;
                        last_take = cyc;
                    end
                end else begin
                    bst_ready = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!fin) chk({req, " completion"}, 0, 1);
        @(negedge clk);
        chk({req, " R12 ready after done"}, int'(req_ready), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 bst_valid", int'(bst_valid), 0);
        chk("R1 done", int'(done), 0);
    endtask

    task automatic t_circ_plain();  xfer("R4 circ no wrap", 14, 'h1000, 4, 63, 10, 0); endtask
    task automatic t_circ_wrap();   xfer("R4 R5 R8 circ wrap stall", 14, 'h1000, 60, 63, 10, 1); endtask
    task automatic t_circ_edge();   xfer("R5 end on wrap", 14, 'h2000, 60, 63, 4, 0); endtask
    task automatic t_circ_multi();  xfer("R2 R5 multi wrap", 14, 'h0300, 3, 7, 20, 1); endtask
    task automatic t_bad_off();
        xfer("R3 offset equal size", 14, 'h0400, 16, 15, 5, 0);
        xfer("R3 offset far out", 14, 'h0400, 200, 15, 40, 1);
    endtask
    task automatic t_max_size();    xfer("R2 all-ones size", 14, 'hFF00, 250, 255, 10, 1); endtask
    task automatic t_linear();      xfer("R6 linear", 15, 'h0800, 200, 15, 100, 1); endtask
    task automatic t_fifo();
        xfer("R7 fifo2", 2, 'h0800, 9, 15, 30, 1);
        xfer("R7 fifo0", 0, 'h0123, 3, 7, 1, 0);
    endtask
    task automatic t_zero();
        xfer("R10 zero len", 14, 'h0100, 5, 31, 0, 0);
        xfer("R10 zero len bad offset", 14, 'h0100, 50, 31, 0, 0);
    endtask
    task automatic t_unsup();       xfer("R11 selector 7", 7, 'h0100, 12, 31, 9, 0); endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        chk("watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_circ_plain();
        t_circ_wrap();
        t_circ_edge();
        t_circ_multi();
        t_bad_off();
        t_max_size();
        t_linear();
        t_fifo();
        t_zero();
        t_unsup();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule